// File: doc/BRIEF.md
# First-order masked GF(2^8) inverter

This block computes the multiplicative inverse of a byte in GF(2^8) while the byte stays split into two Boolean shares. The shares never come together on one wire. The block first turns the Boolean sharing into a multiplicative one, using a random mask that must be non-zero. It then inverts only one of the two multiplicative shares, using a single plain field inverter. Finally it turns the result back into a Boolean sharing, using a second random byte. Products are registered before they are combined, so logic glitches cannot merge the two shares.

All field arithmetic uses the reduction polynomial x^8+x^4+x^3+x+1 (0x11B). The plain inverter maps 0 to 0, so a zero input comes out as a sharing of zero. A caller that needs a different result for zero must handle that outside the block. The pipeline accepts one new byte in every cycle and returns each result two cycles after it was accepted.

Top module: `masked_inv`

## Requirements
- R1: For any input x = in_share0 XOR in_share1 with x != 0, and any non-zero mask_nz, the value out_share0 XOR out_share1 equals the inverse of x under polynomial 0x11B. The result appears two cycles after the input is accepted.
- R2: An input sharing whose recombined value is 0 gives an output sharing whose recombined value is 0.
- R3: out_valid is high in exactly those cycles that come two cycles after a cycle with in_valid high. Inputs on consecutive cycles give results on consecutive cycles, and an idle input cycle gives an idle output cycle.
- R4: After reset, out_valid, out_share0 and out_share1 are all 0 until the first accepted input reaches the output.
- R5: With a valid result, out_share0 equals the field product of mask_rnd and mask_nz, both sampled with that input. The Boolean shares are therefore masked only by the random bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sharing is valid this cycle |
| in_share0 | input | 8 | Boolean share 0 of the operand |
| in_share1 | input | 8 | Boolean share 1 of the operand |
| mask_nz | input | 8 | Random multiplicative mask; must be non-zero |
| mask_rnd | input | 8 | Uniform random byte for the conversion back to Boolean shares |
| out_valid | output | 1 | Result sharing is valid this cycle |
| out_share0 | output | 8 | Boolean share 0 of the inverse |
| out_share1 | output | 8 | Boolean share 1 of the inverse |

## Verification
The hardest cases to reach are the ones where the masks sit at their extremes while the operand is at a boundary. Examples are a multiplicative mask of 1 or 0xFF, a second random byte of 0, and a zero operand hidden behind equal non-zero shares. Random masks alone rarely produce these combinations. The stimulus therefore sweeps all 255 non-zero operands back to back, each with fresh random shares and masks. It then adds directed cycles that pin the masks to these values and break the stream with idle cycles, so the pipeline's valid tracking is exercised with gaps.

// File: rtl/masked_inv.sv
module masked_inv #(
  parameter int       W    = 8,
  parameter logic [W:0] POLY = 9'h11B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_share0,
  input  logic [W-1:0] in_share1,
  input  logic [W-1:0] mask_nz,
  input  logic [W-1:0] mask_rnd,
  output logic         out_valid,
  output logic [W-1:0] out_share0,
  output logic [W-1:0] out_share1
);

  function automatic logic [W-1:0] fmul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] acc;
    logic [W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[W-1] ? ((sh << 1) ^ POLY[W-1:0]) : (sh << 1);
    end
    return acc;
  endfunction

  function automatic logic [W-1:0] finv(input logic [W-1:0] a);
    logic [W-1:0] acc;
    logic [W-1:0] pw;
    acc = {{(W-1){1'b0}}, 1'b1};
    pw  = a;
    for (int i = 0; i < W; i++) begin
      if (i != 0) acc = fmul(acc, pw);
      pw = fmul(pw, pw);
    end
    return acc;
  endfunction

  logic         s1_v, s2_v;
  logic [W-1:0] s1_p0, s1_m0, s1_m1, s1_r1;
  logic [W-1:0] s2_q0, s2_t, s2_r1;
  logic [W-1:0] p1, q1;

  assign p1 = s1_m0 ^ s1_m1;
  assign q1 = finv(p1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_p0 <= '0;
      s1_m0 <= '0;
      s1_m1 <= '0;
      s1_r1 <= '0;
      s2_v  <= 1'b0;
      s2_q0 <= '0;
      s2_t  <= '0;
      s2_r1 <= '0;
    end else begin
      s1_v  <= in_valid;
      s1_p0 <= mask_nz;
      s1_m0 <= fmul(in_share0, mask_nz);
      s1_m1 <= fmul(in_share1, mask_nz);
      s1_r1 <= mask_rnd;
      s2_v  <= s1_v;
      s2_q0 <= s1_p0;
      s2_t  <= q1 ^ s1_r1;
      s2_r1 <= s1_r1;
    end
  end

  assign out_valid  = s2_v;
  assign out_share0 = fmul(s2_r1, s2_q0);
  assign out_share1 = fmul(s2_t, s2_q0);

endmodule

// File: rtl/masked_inv_chk.sv
module masked_inv_chk #(
  parameter int       W    = 8,
  parameter logic [W:0] POLY = 9'h11B
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_share0,
  input logic [W-1:0] in_share1,
  input logic [W-1:0] mask_nz,
  input logic [W-1:0] mask_rnd,
  input logic         out_valid,
  input logic [W-1:0] out_share0,
  input logic [W-1:0] out_share1
);

  function automatic logic [W-1:0] cmul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] acc;
    logic [W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[W-1] ? ((sh << 1) ^ POLY[W-1:0]) : (sh << 1);
    end
    return acc;
  endfunction

  p_inverse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(in_share0, 2) ^ $past(in_share1, 2)) != '0 && $past(mask_nz, 2) != '0)
    |-> cmul(out_share0 ^ out_share1, $past(in_share0, 2) ^ $past(in_share1, 2)) == {{(W-1){1'b0}}, 1'b1});

  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(in_share0, 2) ^ $past(in_share1, 2)) == '0)
    |-> (out_share0 ^ out_share1) == '0);

  p_valid_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  p_valid_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  p_share0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_share0 == cmul($past(mask_rnd, 2), $past(mask_nz, 2)));

endmodule

bind masked_inv masked_inv_chk #(.W(W), .POLY(POLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_share0(in_share0), .in_share1(in_share1),
  .mask_nz(mask_nz), .mask_rnd(mask_rnd),
  .out_valid(out_valid), .out_share0(out_share0), .out_share1(out_share1)
);

// File: tb/masked_inv_tb.sv
module masked_inv_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_share0 = '0, in_share1 = '0, mask_nz = 8'h01, mask_rnd = '0;
  logic       out_valid;
  logic [7:0] out_share0, out_share1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic       ev [0:1023];
  logic [7:0] ex [0:1023];
  logic [7:0] er0 [0:1023];
  logic [7:0] er1 [0:1023];

  always #10 clk = ~clk;

  masked_inv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_share0(in_share0), .in_share1(in_share1),
    .mask_nz(mask_nz), .mask_rnd(mask_rnd),
    .out_valid(out_valid), .out_share0(out_share0), .out_share1(out_share1)
  );

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] t = b;
    logic [7:0] s = a;
    while (t != 0) begin
      if (t[0]) r ^= s;
      s = xt(s);
      t = t >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_inv(input logic [7:0] a);
    for (int y = 1; y < 256; y++)
      if (gm(a, 8'(y)) == 8'h01) return 8'(y);
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic check_out();
    if (cyc >= 2) begin
      int k = cyc - 2;
      chk("R3", {7'b0, out_valid}, {7'b0, ev[k]});
      if (ev[k] && out_valid) begin
        if (ex[k] == 8'h00) chk("R2", out_share0 ^ out_share1, 8'h00);
        else                chk("R1", out_share0 ^ out_share1, ref_inv(ex[k]));
        chk("R5", out_share0, gm(er1[k], er0[k]));
      end
    end
  endtask

  task automatic step(input logic v, input logic [7:0] x, input logic [7:0] r0, input logic [7:0] r1);
    logic [7:0] s0;
    @(negedge clk);
    check_out();
    s0 = 8'($urandom);
    in_valid  = v;
    in_share0 = s0;
    in_share1 = s0 ^ x;
    mask_nz   = r0;
    mask_rnd  = r1;
    ev[cyc] = v; ex[cyc] = x; er0[cyc] = r0; er1[cyc] = r1;
    cyc++;
  endtask

  function automatic logic [7:0] rnz();
    logic [7:0] r;
    r = 8'($urandom);
    return (r == 8'h00) ? 8'h5A : r;
  endfunction

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4", {7'b0, out_valid}, 8'h00);
    chk("R4", out_share0, 8'h00);
    chk("R4", out_share1, 8'h00);

    for (int x = 1; x < 256; x++) step(1'b1, 8'(x), rnz(), 8'($urandom));

    step(1'b1, 8'h00, rnz(), 8'($urandom));
    step(1'b1, 8'h53, 8'h01, 8'h00);
    step(1'b1, 8'h01, 8'hFF, 8'hFF);
    step(1'b1, 8'hFF, 8'h01, 8'hFF);
    step(1'b0, 8'h10, rnz(), 8'($urandom));
    step(1'b1, 8'h00, 8'h01, 8'h00);
    step(1'b0, 8'h22, rnz(), 8'($urandom));
    step(1'b0, 8'h33, rnz(), 8'($urandom));
    step(1'b1, 8'h80, 8'h80, 8'h7F);
    step(1'b0, 8'h00, 8'h01, 8'h00);
    for (int i = 0; i < 40; i++) step(i[0], 8'($urandom), rnz(), 8'($urandom));
    step(1'b0, 8'h00, 8'h01, 8'h00);
    step(1'b0, 8'h00, 8'h01, 8'h00);
    step(1'b0, 8'h00, 8'h01, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule